// File: doc/BRIEF.md
# Machine State Register Write Unit

This block holds a processor's machine state register and applies the write policy that decides which value is stored. A write request carries a new value and a flag that says whether the hypervisor bit may change. The unit masks the value down to the implemented bits. It protects the hypervisor bit and forces the privilege-dependent enables. It then loads the result on the clock edge where the write strobe is high.

The stored value drives two 3-bit memory-management mode indices, one for instruction fetch and one for data access. A static mode input selects between a server encoding and an embedded encoding. The block also raises one-cycle side-effect strobes for the surrounding core: a translation flush request, a request to swap the four shadow registers, an exception-prefix update together with a registered exception base, and a halt request. A derived-flags output combines a fixed subset of the register with flags supplied from outside.

The bit positions, the writable mask, the flags mask and the reset value are parameters. The encoding choice, the 64-bit server forcing rule and the shadow-register feature are static inputs.

Top module: `msr_write_unit`

## Requirements
- R1: Reset loads the parameter RESET_MSR (default: only the hypervisor bit, bit 60, set). The register changes only on an edge where wr_en is high, and then it takes wr_data ANDed with WMASK (default 64'h1000_0000_FFFF_FFFF), modified by R2 and R6.
- R2: The hypervisor bit (bit 60) keeps its old value unless wr_hv_ok is high and the old value of the bit is 1. In that case it takes the written bit.
- R3: flush_req pulses when a write changes the instruction-relocate bit (bit 5) or the data-relocate bit (bit 4). With mode_embedded high, a change of the guest-state bit (bit 28) also makes it pulse.
- R4: swap_req pulses when feat_tgpr is high and a write toggles the shadow-register bit (bit 17). With feat_tgpr low it stays low.
- R5: When a write changes the exception-prefix bit (bit 6), prefix_upd pulses and excp_base becomes 32'hFFF0_0000 if the new bit is 1, or 0 if it is 0. Otherwise excp_base holds its value.
- R6: With mode_server64 high, a stored problem-state bit (bit 14) equal to 1 forces bits 15 (external interrupt enable), 5 and 4 to 1. With mode_server64 low, nothing is forced.
- R7: With mode_embedded low, each index equals (PR?0:1)+(reloc?0:2)+(HV?4:0). The instruction index uses bit 5 and the data index uses bit 4.
- R8: With mode_embedded high, each index equals (PR?0:1)+(AS?2:0)+(GS?4:0). The instruction index uses the address-space bit at bit 5 and the data index uses the one at bit 4.
- R9: halt pulses after a write that stores the power-save bit (bit 18) as 1 while irq_pending is low and pow_allowed is high.
- R10: flags_out equals (msr_q AND FLAGS_MASK) OR ext_flags. The default mask covers bits 60, 15, 14, 5, 4 and 0.
- R11: Every strobe (flush_req, swap_req, prefix_upd, halt) is high for exactly the one cycle after the accepting edge, and is low after any edge without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Value to write |
| wr_hv_ok | input | 1 | Write may alter the hypervisor bit |
| mode_embedded | input | 1 | Selects embedded index encoding and guest-state flush |
| mode_server64 | input | 1 | Enables problem-state forcing |
| feat_tgpr | input | 1 | Enables shadow-register swap requests |
| irq_pending | input | 1 | An interrupt is pending |
| pow_allowed | input | 1 | Power-save halt is permitted |
| ext_flags | input | XLEN | Flags merged into flags_out |
| msr_q | output | XLEN | Stored register value |
| flags_out | output | XLEN | Derived flags |
| immu_idx | output | 3 | Instruction-fetch mode index |
| dmmu_idx | output | 3 | Data-access mode index |
| flush_req | output | 1 | Translation flush strobe |
| swap_req | output | 1 | Shadow-register swap strobe |
| prefix_upd | output | 1 | Exception prefix changed strobe |
| excp_base | output | 32 | Registered exception base |
| halt | output | 1 | Halt strobe |

## Verification
A write presented with wr_en changes msr_q, the strobes and excp_base after the single clock edge that accepts it. The two indices and flags_out follow msr_q with no further delay, and the strobes fall again one edge later. The bench changes inputs on the falling edge and compares every output against its behavioural model at the next falling edge. It advances the model only for the edge just passed, so each result is checked in the exact cycle it is due and every strobe is checked again in the following idle cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

    // Side-effect strobes produced by one accepted write
    typedef struct packed {
        logic flush;
        logic swap;
        logic prefix;
        logic halt;
    } msr_fx_t;

    // Fields of the register that the index logic looks at
    typedef struct packed {
        logic pr;
        logic hv;
        logic gs;
        logic ir;
        logic dr;
        logic as_i;
        logic as_d;
    } msr_view_t;

    localparam logic [31:0] EXCP_BASE_HIGH = 32'hFFF0_0000;

    // Server form: the low bit says supervisor, the middle bit says translation off
    function automatic logic [2:0] idx_server(input logic pr, input logic reloc,
                                              input logic hv);
        return {hv, ~reloc, ~pr};
    endfunction

    // Embedded form: the middle bit is the address-space selector
    function automatic logic [2:0] idx_embedded(input logic pr, input logic aspace,
                                                input logic gs);
        return {gs, aspace, ~pr};
    endfunction

    function automatic logic [31:0] base_for(input logic ep);
        return ep ? EXCP_BASE_HIGH : 32'h0;
    endfunction

endpackage

// File: rtl/msr_write_policy.sv
module msr_write_policy
    import msr_pkg::*;
#(
    parameter int            XLEN    = 64,
    parameter logic [XLEN-1:0] WMASK = 64'h1000_0000_FFFF_FFFF,
    parameter int            POS_HV  = 60,
    parameter int            POS_PR  = 14,
    parameter int            POS_EE  = 15,
    parameter int            POS_IR  = 5,
    parameter int            POS_DR  = 4
) (
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_hv_ok,
    input  logic            mode_server64,
    output logic [XLEN-1:0] nxt
);

    logic [XLEN-1:0] masked;
    logic            hv_may_change;

    assign masked        = wr_data & WMASK;
    assign hv_may_change = wr_hv_ok & cur[POS_HV];

    always_comb begin
        nxt = masked;
        if (!hv_may_change) begin
            nxt[POS_HV] = cur[POS_HV];
        end
        if (mode_server64 && nxt[POS_PR]) begin
            nxt[POS_EE] = 1'b1;
            nxt[POS_IR] = 1'b1;
            nxt[POS_DR] = 1'b1;
        end
    end

endmodule

// File: rtl/msr_mmu_index.sv
module msr_mmu_index
    import msr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int POS_HV = 60,
    parameter int POS_PR = 14,
    parameter int POS_IR = 5,
    parameter int POS_DR = 4,
    parameter int POS_IS = 5,
    parameter int POS_DS = 4,
    parameter int POS_GS = 28
) (
    input  logic [XLEN-1:0] msr,
    input  logic            mode_embedded,
    output logic [2:0]      immu_idx,
    output logic [2:0]      dmmu_idx
);

    msr_view_t v;

    always_comb begin
        v.pr   = msr[POS_PR];
        v.hv   = msr[POS_HV];
        v.gs   = msr[POS_GS];
        v.ir   = msr[POS_IR];
        v.dr   = msr[POS_DR];
        v.as_i = msr[POS_IS];
        v.as_d = msr[POS_DS];
    end

    always_comb begin
        if (mode_embedded) begin
            immu_idx = idx_embedded(v.pr, v.as_i, v.gs);
            dmmu_idx = idx_embedded(v.pr, v.as_d, v.gs);
        end else begin
            immu_idx = idx_server(v.pr, v.ir, v.hv);
            dmmu_idx = idx_server(v.pr, v.dr, v.hv);
        end
    end

endmodule

// File: rtl/msr_effects.sv
module msr_effects
    import msr_pkg::*;
#(
    parameter int    XLEN       = 64,
    parameter int    POS_IR     = 5,
    parameter int    POS_DR     = 4,
    parameter int    POS_GS     = 28,
    parameter int    POS_TGPR   = 17,
    parameter int    POS_EP     = 6,
    parameter int    POS_POW    = 18,
    parameter logic  RESET_EP   = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] nxt,
    input  logic            mode_embedded,
    input  logic            feat_tgpr,
    input  logic            irq_pending,
    input  logic            pow_allowed,
    output msr_fx_t         fx_q,
    output logic [31:0]     excp_base
);

    msr_fx_t fx_d;
    logic [XLEN-1:0] diff;

    assign diff = cur ^ nxt;

    always_comb begin
        fx_d.flush  = diff[POS_IR] | diff[POS_DR] | (mode_embedded & diff[POS_GS]);
        fx_d.swap   = feat_tgpr & diff[POS_TGPR];
        fx_d.prefix = diff[POS_EP];
        fx_d.halt   = nxt[POS_POW] & ~irq_pending & pow_allowed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fx_q      <= '0;
            excp_base <= base_for(RESET_EP);
        end else begin
            fx_q <= wr_en ? fx_d : '0;
            if (wr_en && fx_d.prefix) begin
                excp_base <= base_for(nxt[POS_EP]);
            end
        end
    end

endmodule

// File: rtl/msr_write_unit.sv
module msr_write_unit
    import msr_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter logic [XLEN-1:0] WMASK      = 64'h1000_0000_FFFF_FFFF,
    parameter logic [XLEN-1:0] FLAGS_MASK = 64'h1000_0000_0000_C031,
    parameter logic [XLEN-1:0] RESET_MSR  = 64'h1000_0000_0000_0000,
    parameter int              POS_HV     = 60,
    parameter int              POS_PR     = 14,
    parameter int              POS_EE     = 15,
    parameter int              POS_IR     = 5,
    parameter int              POS_DR     = 4,
    parameter int              POS_IS     = 5,
    parameter int              POS_DS     = 4,
    parameter int              POS_GS     = 28,
    parameter int              POS_TGPR   = 17,
    parameter int              POS_EP     = 6,
    parameter int              POS_POW    = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_hv_ok,
    input  logic            mode_embedded,
    input  logic            mode_server64,
    input  logic            feat_tgpr,
    input  logic            irq_pending,
    input  logic            pow_allowed,
    input  logic [XLEN-1:0] ext_flags,
    output logic [XLEN-1:0] msr_q,
    output logic [XLEN-1:0] flags_out,
    output logic [2:0]      immu_idx,
    output logic [2:0]      dmmu_idx,
    output logic            flush_req,
    output logic            swap_req,
    output logic            prefix_upd,
    output logic [31:0]     excp_base,
    output logic            halt
);

    localparam logic RESET_EP = RESET_MSR[POS_EP];

    logic [XLEN-1:0] msr_nxt;
    msr_fx_t         fx_q;

    msr_write_policy #(
        .XLEN(XLEN), .WMASK(WMASK), .POS_HV(POS_HV), .POS_PR(POS_PR),
        .POS_EE(POS_EE), .POS_IR(POS_IR), .POS_DR(POS_DR)
    ) u_policy (
        .cur           (msr_q),
        .wr_data       (wr_data),
        .wr_hv_ok      (wr_hv_ok),
        .mode_server64 (mode_server64),
        .nxt           (msr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q <= RESET_MSR;
        end else if (wr_en) begin
            msr_q <= msr_nxt;
        end
    end

    msr_effects #(
        .XLEN(XLEN), .POS_IR(POS_IR), .POS_DR(POS_DR), .POS_GS(POS_GS),
        .POS_TGPR(POS_TGPR), .POS_EP(POS_EP), .POS_POW(POS_POW),
        .RESET_EP(RESET_EP)
    ) u_effects (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .cur           (msr_q),
        .nxt           (msr_nxt),
        .mode_embedded (mode_embedded),
        .feat_tgpr     (feat_tgpr),
        .irq_pending   (irq_pending),
        .pow_allowed   (pow_allowed),
        .fx_q          (fx_q),
        .excp_base     (excp_base)
    );

    msr_mmu_index #(
        .XLEN(XLEN), .POS_HV(POS_HV), .POS_PR(POS_PR), .POS_IR(POS_IR),
        .POS_DR(POS_DR), .POS_IS(POS_IS), .POS_DS(POS_DS), .POS_GS(POS_GS)
    ) u_index (
        .msr           (msr_q),
        .mode_embedded (mode_embedded),
        .immu_idx      (immu_idx),
        .dmmu_idx      (dmmu_idx)
    );

    assign flags_out  = (msr_q & FLAGS_MASK) | ext_flags;
    assign flush_req  = fx_q.flush;
    assign swap_req   = fx_q.swap;
    assign prefix_upd = fx_q.prefix;
    assign halt       = fx_q.halt;

endmodule

// File: rtl/msr_write_unit_chk.sv
module msr_write_unit_chk #(
    parameter int              XLEN      = 64,
    parameter logic [XLEN-1:0] WMASK     = 64'h1000_0000_FFFF_FFFF,
    parameter logic [XLEN-1:0] RESET_MSR = 64'h1000_0000_0000_0000,
    parameter int              POS_HV    = 60,
    parameter int              POS_PR    = 14,
    parameter int              POS_EE    = 15,
    parameter int              POS_IR    = 5,
    parameter int              POS_DR    = 4,
    parameter int              POS_POW   = 18
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            wr_hv_ok,
    input logic            mode_server64,
    input logic [XLEN-1:0] msr_q,
    input logic            flush_req,
    input logic            swap_req,
    input logic            prefix_upd,
    input logic            halt,
    input logic [31:0]     excp_base
);

    localparam logic [XLEN-1:0] FORCED = (XLEN'(1) << POS_EE) | (XLEN'(1) << POS_IR)
                                       | (XLEN'(1) << POS_DR);
    localparam logic [XLEN-1:0] LEGAL  = WMASK | FORCED | RESET_MSR;

    // R1
    no_stray_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_q & ~LEGAL) == '0);

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(msr_q));

    // R2
    hv_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(wr_hv_ok && msr_q[POS_HV])) |=> $stable(msr_q[POS_HV]));

    // R6
    pr_forces_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_server64) |=>
            (!msr_q[POS_PR] || (msr_q[POS_EE] && msr_q[POS_IR] && msr_q[POS_DR])));

    // R11
    no_pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !(flush_req || swap_req || prefix_upd || halt));

    // R5
    base_values_chk: assert property (@(posedge clk) disable iff (rst)
        (excp_base == 32'h0) || (excp_base == 32'hFFF0_0000));

    // R5
    base_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !prefix_upd |-> $stable(excp_base));

    // R9
    halt_needs_pow_chk: assert property (@(posedge clk) disable iff (rst)
        halt |-> msr_q[POS_POW]);

endmodule

bind msr_write_unit msr_write_unit_chk #(
    .XLEN(XLEN), .WMASK(WMASK), .RESET_MSR(RESET_MSR), .POS_HV(POS_HV),
    .POS_PR(POS_PR), .POS_EE(POS_EE), .POS_IR(POS_IR), .POS_DR(POS_DR),
    .POS_POW(POS_POW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_hv_ok      (wr_hv_ok),
    .mode_server64 (mode_server64),
    .msr_q         (msr_q),
    .flush_req     (flush_req),
    .swap_req      (swap_req),
    .prefix_upd    (prefix_upd),
    .halt          (halt),
    .excp_base     (excp_base)
);

// File: tb/msr_write_unit_tb.sv
module msr_write_unit_tb;

    localparam logic [63:0] WM  = 64'h1000_0000_FFFF_FFFF;
    localparam logic [63:0] FM  = 64'h1000_0000_0000_C031;
    localparam logic [63:0] RST = 64'h1000_0000_0000_0000;
    localparam int B_HV = 60, B_PR = 14, B_EE = 15, B_IR = 5, B_DR = 4;
    localparam int B_GS = 28, B_TG = 17, B_EP = 6, B_PW = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_hv_ok = 1'b0;
    logic        mode_embedded = 1'b0;
    logic        mode_server64 = 1'b0;
    logic        feat_tgpr = 1'b0;
    logic        irq_pending = 1'b0;
    logic        pow_allowed = 1'b0;
    logic [63:0] ext_flags = '0;
    logic [63:0] msr_q, flags_out;
    logic [2:0]  immu_idx, dmmu_idx;
    logic        flush_req, swap_req, prefix_upd, halt;
    logic [31:0] excp_base;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_msr;
    logic [31:0] m_base;
    logic        m_flush, m_swap, m_pfx, m_halt;

    always #5 clk = ~clk;

    msr_write_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_hv_ok(wr_hv_ok),
        .mode_embedded(mode_embedded), .mode_server64(mode_server64),
        .feat_tgpr(feat_tgpr), .irq_pending(irq_pending), .pow_allowed(pow_allowed),
        .ext_flags(ext_flags), .msr_q(msr_q), .flags_out(flags_out),
        .immu_idx(immu_idx), .dmmu_idx(dmmu_idx), .flush_req(flush_req),
        .swap_req(swap_req), .prefix_upd(prefix_upd), .excp_base(excp_base),
        .halt(halt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ref_idx(input logic [63:0] m, input logic emb, input int sel);
        int r;
        r = m[B_PR] ? 0 : 1;
        if (emb) begin
            r += m[sel] ? 2 : 0;
            r += m[B_GS] ? 4 : 0;
        end else begin
            r += m[sel] ? 0 : 2;
            r += m[B_HV] ? 4 : 0;
        end
        return r;
    endfunction

    task automatic compare_all();
        chk("R1", msr_q, m_msr);
        if (mode_embedded) begin
            chk("R8", 64'(immu_idx), 64'(ref_idx(m_msr, 1'b1, B_IR)));
            chk("R8", 64'(dmmu_idx), 64'(ref_idx(m_msr, 1'b1, B_DR)));
        end else begin
            chk("R7", 64'(immu_idx), 64'(ref_idx(m_msr, 1'b0, B_IR)));
            chk("R7", 64'(dmmu_idx), 64'(ref_idx(m_msr, 1'b0, B_DR)));
        end
        chk("R10", flags_out, (m_msr & FM) | ext_flags);
        chk("R3", 64'(flush_req), 64'(m_flush));
        chk("R4", 64'(swap_req), 64'(m_swap));
        chk("R5", 64'(prefix_upd), 64'(m_pfx));
        chk("R5", 64'(excp_base), 64'(m_base));
        chk("R9", 64'(halt), 64'(m_halt));
    endtask

    // Advance one clock; inputs are set at a falling edge, results read at the next one
    task automatic tick(input logic we, input logic [63:0] d, input logic hv);
        logic [63:0] v;
        logic [63:0] old;
        old = m_msr;
        v = old;
        wr_en = we;
        wr_data = d;
        wr_hv_ok = hv;
        if (we) begin
            v = d & WM;
            if (!(hv && old[B_HV])) v[B_HV] = old[B_HV];
            if (mode_server64 && v[B_PR]) begin
                v[B_EE] = 1'b1;
                v[B_IR] = 1'b1;
                v[B_DR] = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_flush = we && ((old[B_IR] != v[B_IR]) || (old[B_DR] != v[B_DR]) ||
                         (mode_embedded && old[B_GS] != v[B_GS]));
        m_swap  = we && feat_tgpr && (old[B_TG] != v[B_TG]);
        m_pfx   = we && (old[B_EP] != v[B_EP]);
        m_halt  = we && v[B_PW] && !irq_pending && pow_allowed;
        if (m_pfx) m_base = v[B_EP] ? 32'hFFF0_0000 : 32'h0;
        m_msr = v;
        compare_all();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    localparam logic [63:0] IR = 64'd1 << B_IR, DR = 64'd1 << B_DR, HV = 64'd1 << B_HV;
    localparam logic [63:0] PR = 64'd1 << B_PR, TG = 64'd1 << B_TG, EP = 64'd1 << B_EP;
    localparam logic [63:0] PW = 64'd1 << B_PW, GS = 64'd1 << B_GS;

    initial begin
        m_msr = RST; m_base = '0;
        m_flush = 0; m_swap = 0; m_pfx = 0; m_halt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        compare_all();
        chk("R1", msr_q, RST);
        tick(0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        mode_server64 = 1; feat_tgpr = 1;
        // R2: HV kept while wr_hv_ok is low
        tick(1, IR | DR, 0);
        chk("R2", 64'(msr_q[B_HV]), 64'd1);
        // R2: HV set and allowed -> cleared
        tick(1, IR | DR, 1);
        chk("R2", 64'(msr_q[B_HV]), 64'd0);
        // R2: HV now clear -> cannot be set again
        tick(1, HV | IR | DR, 1);
        chk("R2", 64'(msr_q[B_HV]), 64'd0);
        // R6: problem state forces enables
        tick(1, PR, 0);
        chk("R6", msr_q & 64'h0000_0000_0000_C030, 64'h0000_0000_0000_C030);
        // R4/R5 swap and prefix
        tick(1, TG | EP, 0);
        // R11: strobes drop on idle cycle
        tick(0, '0, 0);
        tick(1, TG | EP, 0);
        tick(1, 64'h0, 0);
        // R9 halt variants
        pow_allowed = 1;
        tick(1, PW, 0);
        irq_pending = 1;
        tick(1, PW | IR, 0);
        irq_pending = 0; pow_allowed = 0;
        tick(1, PW, 0);
        // R1 unwritable bit 40 dropped
        tick(1, (64'd1 << 40) | 64'd8, 0);
        chk("R1", 64'(msr_q[40]), 64'd0);
        // R6 no forcing outside server64
        mode_server64 = 0;
        tick(1, PR, 0);
        chk("R6", 64'(msr_q[B_EE]), 64'd0);
        // R3/R8 embedded mode
        mode_embedded = 1;
        tick(1, GS | IR, 0);
        tick(1, GS | DR, 0);
        tick(1, DR, 0);
        // R4 feature off
        feat_tgpr = 0;
        tick(1, TG | DR, 0);
        chk("R4", 64'(swap_req), 64'd0);
        // R10 external flags merge
        ext_flags = 64'h0000_0100_0000_0002;
        tick(0, '0, 0);
        mode_embedded = 0;
        tick(1, PR | IR, 0);
        tick(0, '0, 0);
        report();
        $finish;
    end

endmodule